// File: doc/BRIEF.md
# Linked display node fetcher

This block loads the configuration of one display plane from memory. The configuration is a chain of 16-word nodes. A next-node pointer register, which software can write, names the node to load. At every vertical sync with a usable pointer, the block reads all sixteen words of that node, one request at a time, through a simple memory read port. Each word is stored in a staging set as it arrives. The whole node is then copied at once into shadow registers that the display path reads.

Each node carries a link word, and that word becomes the next pointer. Two nodes that point at each other form a top/bottom field pair. Software can prepare a second pair and redirect the chain to it without ever editing a node the display is using. A node can also ask to be held back until the following sync. The block alternates a field indicator at every sync and reports the address of the node now in force. It also reports whether the plane must be hidden, a sticky underflow seen since the last load, and a sticky error for a misaligned pointer.

Top module: `plane_node_loader`

## Requirements
- R1: After reset the shadow outputs, the loaded address, the field indicator, the underflow flag and the alignment error are all zero, and no memory request is issued.
- R2: A vsync that finds the block idle and the pointer non-zero and aligned reads the 16 node words. The reads go to byte addresses pointer+4*k for k = 0..15, in ascending order, with at most one read outstanding. A vsync that arrives while a fetch is still running is ignored and does not restart the fetch.
- R3: A vsync while the pointer is zero starts no read.
- R4: A pointer whose low ALIGN_BITS bits (4 by default) are not all zero starts no read at vsync. The shadow values stay unchanged and a sticky alignment error is set.
- R5: All shadow fields and the loaded address change together, in one cycle, and only after all 16 words of a node have arrived.
- R6: Word 9 of a fetched node (its link) becomes the next pointer, so the next vsync loads the node it names.
- R7: A software pointer write made during a fetch does not abort that fetch. The link word of that fetch does not replace the written value, so the next vsync loads the written address.
- R8: If bit 31 of a node's word 0 (control) is set, the shadow update waits for the next vsync and happens in that vsync's cycle. If the bit is clear, the update happens as soon as the fetch completes.
- R9: The field indicator toggles at every vsync, busy or not, and holds otherwise.
- R10: The plane-hidden output is high exactly when bit 0 or bit 1 of the loaded word 13 (properties) is set. Other bits of that word do not affect it.
- R11: Width is word 7 bits [15:0] and height is word 7 bits [31:16]. On output they are limited to MAX_W and MAX_H, and values at or below the limits pass unchanged.
- R12: A pulse on the underflow input sets a sticky underflow output, which is cleared when a new node is committed to the shadow registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vsync_i | input | 1 | One-cycle vertical sync pulse |
| ptr_we_i | input | 1 | Software write strobe for the next-node pointer |
| ptr_wdata_i | input | ADDR_W | Pointer value written by software |
| mem_req_o | output | 1 | One-cycle read request |
| mem_addr_o | output | ADDR_W | Byte address of the requested word |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 32 | Read data |
| underflow_i | input | 1 | Underflow pulse from the display path |
| cfg_ctrl_o | output | 32 | Shadow control word (word 0) |
| cfg_alpha_o | output | 32 | Shadow alpha gain (word 1) |
| cfg_origin_o | output | 32 | Shadow viewport origin, line [31:16], pixel [15:0] (word 3) |
| cfg_stop_o | output | 32 | Shadow viewport stop, line [31:16], pixel [15:0] (word 4) |
| cfg_pix_addr_o | output | 32 | Shadow pixel memory address (word 5) |
| cfg_pitch_o | output | 32 | Shadow line pitch (word 6) |
| cfg_size_o | output | 32 | Clamped size, height [31:16], width [15:0] (word 7) |
| cfg_key_a_o | output | 32 | Shadow first colour key (word 10) |
| cfg_key_b_o | output | 32 | Shadow second colour key (word 11) |
| cfg_props_o | output | 32 | Shadow properties (word 13) |
| cfg_clut_o | output | 32 | Shadow colour lookup address (word 15) |
| loaded_addr_o | output | ADDR_W | Address of the node now in the shadow registers |
| field_bot_o | output | 1 | Field indicator, toggles each vsync |
| plane_hidden_o | output | 1 | Plane must not be shown |
| underflow_o | output | 1 | Sticky underflow since the last commit |
| align_err_o | output | 1 | Sticky misaligned-pointer error |

## Verification
The bench builds the block with MAX_W = 320 and MAX_H = 240 and keeps ADDR_W = 32 and ALIGN_BITS = 4. The small limits make the clamp reachable with modest node values. A node exactly at the limits checks that the clamp is inclusive, and an oversized node checks that both fields are cut. The memory model answers each read two cycles after the request. This leaves a window of roughly fifty cycles per fetch, wide enough to look at the shadow outputs halfway through a load and to place a pointer write and a stray vsync inside a fetch that is still running.

// File: rtl/pnl_pkg.sv
package pnl_pkg;
   localparam int unsigned NODE_WORDS = 16;
   localparam int unsigned IDX_W      = $clog2(NODE_WORDS);

   // word positions inside a node (decoded by memory layout)
   localparam int unsigned W_CTRL    = 0;
   localparam int unsigned W_ALPHA   = 1;
   localparam int unsigned W_ORIGIN  = 3;
   localparam int unsigned W_STOP    = 4;
   localparam int unsigned W_PIXADDR = 5;
   localparam int unsigned W_PITCH   = 6;
   localparam int unsigned W_SIZE    = 7;
   localparam int unsigned W_LINK    = 9;
   localparam int unsigned W_KEYA    = 10;
   localparam int unsigned W_KEYB    = 11;
   localparam int unsigned W_PROPS   = 13;
   localparam int unsigned W_CLUT    = 15;

   localparam int unsigned DEFER_BIT = 31;

   typedef struct packed {
      logic [31:0] props;
      logic [31:0] size;
      logic [31:0] ctrl;
      logic [31:0] pix_addr;
      logic [31:0] pitch;
      logic [31:0] origin;
      logic [31:0] stop;
      logic [31:0] alpha;
      logic [31:0] key_a;
      logic [31:0] key_b;
      logic [31:0] clut;
   } node_t;

   // true for the words kept in the staging set (reserved slots and the link are not)
   function automatic bit slot_kept(int unsigned w);
      return (w == W_CTRL)   || (w == W_ALPHA)   || (w == W_ORIGIN) ||
             (w == W_STOP)   || (w == W_PIXADDR) || (w == W_PITCH)  ||
             (w == W_SIZE)   || (w == W_KEYA)    || (w == W_KEYB)   ||
             (w == W_PROPS)  || (w == W_CLUT);
   endfunction
endpackage

// File: rtl/pnl_fetch_seq.sv
module pnl_fetch_seq
   import pnl_pkg::*;
#(
   parameter int unsigned ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [ADDR_W-1:0] base_i,
   input  logic              mem_rvalid_i,
   output logic              mem_req_o,
   output logic [ADDR_W-1:0] mem_addr_o,
   output logic              busy_o,
   output logic              word_valid_o,
   output logic [IDX_W-1:0]  word_idx_o
);
   localparam int unsigned PAD_W = ADDR_W - IDX_W - 2;
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NODE_WORDS - 1);

   typedef enum logic [1:0] {S_IDLE, S_REQ, S_WAIT} seq_state_e;

   seq_state_e        state_q;
   logic [IDX_W-1:0]  idx_q;
   logic [ADDR_W-1:0] base_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= S_IDLE;
         idx_q   <= '0;
         base_q  <= '0;
      end else begin
         unique case (state_q)
            S_IDLE: if (start_i) begin
               base_q  <= base_i;
               idx_q   <= '0;
               state_q <= S_REQ;
            end
            S_REQ:  state_q <= S_WAIT;
            S_WAIT: if (mem_rvalid_i) begin
               if (idx_q == LAST_IDX) begin
                  state_q <= S_IDLE;
               end else begin
                  idx_q   <= idx_q + 1'b1;
                  state_q <= S_REQ;
               end
            end
            default: state_q <= S_IDLE;
         endcase
      end
   end

   assign mem_req_o    = (state_q == S_REQ);
   assign mem_addr_o   = base_q + {{PAD_W{1'b0}}, idx_q, 2'b00};
   assign busy_o       = (state_q != S_IDLE);
   assign word_valid_o = (state_q == S_WAIT) && mem_rvalid_i;
   assign word_idx_o   = idx_q;
endmodule

// File: rtl/pnl_node_stage.sv
module pnl_node_stage
   import pnl_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             word_valid_i,
   input  logic [IDX_W-1:0] word_idx_i,
   input  logic [31:0]      word_data_i,
   output node_t            node_o,
   output logic             complete_o
);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NODE_WORDS - 1);

   for (genvar w = 0; w < NODE_WORDS; w++) begin : g_slot
      if (slot_kept(w)) begin : g_keep
         logic [31:0] q;
         always_ff @(posedge clk) begin
            if (!rst_n)
               q <= '0;
            else if (word_valid_i && (word_idx_i == IDX_W'(w)))
               q <= word_data_i;
         end
      end
   end

   always_comb begin
      node_o          = '0;
      node_o.ctrl     = g_slot[W_CTRL].g_keep.q;
      node_o.alpha    = g_slot[W_ALPHA].g_keep.q;
      node_o.origin   = g_slot[W_ORIGIN].g_keep.q;
      node_o.stop     = g_slot[W_STOP].g_keep.q;
      node_o.pix_addr = g_slot[W_PIXADDR].g_keep.q;
      node_o.pitch    = g_slot[W_PITCH].g_keep.q;
      node_o.size     = g_slot[W_SIZE].g_keep.q;
      node_o.key_a    = g_slot[W_KEYA].g_keep.q;
      node_o.key_b    = g_slot[W_KEYB].g_keep.q;
      node_o.props    = g_slot[W_PROPS].g_keep.q;
      node_o.clut     = g_slot[W_CLUT].g_keep.q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         complete_o <= 1'b0;
      else
         complete_o <= word_valid_i && (word_idx_i == LAST_IDX);
   end
endmodule

// File: rtl/pnl_shadow.sv
module pnl_shadow
   import pnl_pkg::*;
#(
   parameter int unsigned ADDR_W   = 32,
   parameter int unsigned MAX_W    = 3840,
   parameter int unsigned MAX_H    = 2160,
   parameter bit          CLAMP_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              commit_i,
   input  node_t             node_i,
   input  logic [ADDR_W-1:0] addr_i,
   output node_t             node_o,
   output logic [ADDR_W-1:0] addr_o
);
   logic [31:0] size_lim;
   node_t       node_c;

   if (CLAMP_EN) begin : g_clamp
      localparam logic [15:0] LIM_W = 16'(MAX_W);
      localparam logic [15:0] LIM_H = 16'(MAX_H);
      always_comb begin
         size_lim[15:0]  = (node_i.size[15:0]  > LIM_W) ? LIM_W : node_i.size[15:0];
         size_lim[31:16] = (node_i.size[31:16] > LIM_H) ? LIM_H : node_i.size[31:16];
      end
   end else begin : g_pass
      assign size_lim = node_i.size;
   end

   always_comb begin
      node_c      = node_i;
      node_c.size = size_lim;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         node_o <= '0;
         addr_o <= '0;
      end else if (commit_i) begin
         node_o <= node_c;
         addr_o <= addr_i;
      end
   end
endmodule

// File: rtl/plane_node_loader.sv
module plane_node_loader
   import pnl_pkg::*;
#(
   parameter int unsigned ADDR_W     = 32,
   parameter int unsigned ALIGN_BITS = 4,
   parameter int unsigned MAX_W      = 3840,
   parameter int unsigned MAX_H      = 2160,
   parameter bit          CLAMP_EN   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              vsync_i,
   input  logic              ptr_we_i,
   input  logic [ADDR_W-1:0] ptr_wdata_i,
   output logic              mem_req_o,
   output logic [ADDR_W-1:0] mem_addr_o,
   input  logic              mem_rvalid_i,
   input  logic [31:0]       mem_rdata_i,
   input  logic              underflow_i,
   output logic [31:0]       cfg_ctrl_o,
   output logic [31:0]       cfg_alpha_o,
   output logic [31:0]       cfg_origin_o,
   output logic [31:0]       cfg_stop_o,
   output logic [31:0]       cfg_pix_addr_o,
   output logic [31:0]       cfg_pitch_o,
   output logic [31:0]       cfg_size_o,
   output logic [31:0]       cfg_key_a_o,
   output logic [31:0]       cfg_key_b_o,
   output logic [31:0]       cfg_props_o,
   output logic [31:0]       cfg_clut_o,
   output logic [ADDR_W-1:0] loaded_addr_o,
   output logic              field_bot_o,
   output logic              plane_hidden_o,
   output logic              underflow_o,
   output logic              align_err_o
);
   // elaboration-time parameter checks
   if (ADDR_W != 32) begin : g_bad_addr
      $error("plane_node_loader: ADDR_W must equal the 32-bit link word");
   end
   if (ALIGN_BITS < 2 || ALIGN_BITS >= ADDR_W) begin : g_bad_align
      $error("plane_node_loader: ALIGN_BITS out of range");
   end
   if (MAX_W == 0 || MAX_W > 65535 || MAX_H == 0 || MAX_H > 65535) begin : g_bad_lim
      $error("plane_node_loader: size limits must fit 16 bits");
   end

   localparam logic [IDX_W-1:0] LINK_IDX = IDX_W'(W_LINK);

   logic [ADDR_W-1:0] next_ptr_q;
   logic [ADDR_W-1:0] fetch_base_q;
   logic              field_q, pending_q, sw_hold_q, err_q, unf_q;
   logic              seq_busy, word_valid, complete, busy;
   logic [IDX_W-1:0]  word_idx;
   logic              ptr_zero, ptr_misaligned, launch, bad_launch, commit, link_hit;
   node_t             staged, shadow;

   assign busy           = seq_busy | complete;
   assign ptr_zero       = (next_ptr_q == '0);
   assign ptr_misaligned = |next_ptr_q[ALIGN_BITS-1:0];
   assign launch         = vsync_i && !busy && !ptr_zero && !ptr_misaligned;
   assign bad_launch     = vsync_i && !busy && !ptr_zero && ptr_misaligned;
   assign commit         = (vsync_i && pending_q) || (complete && !staged.ctrl[DEFER_BIT]);
   assign link_hit       = word_valid && (word_idx == LINK_IDX);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         next_ptr_q   <= '0;
         fetch_base_q <= '0;
         field_q      <= 1'b0;
         pending_q    <= 1'b0;
         sw_hold_q    <= 1'b0;
         err_q        <= 1'b0;
         unf_q        <= 1'b0;
      end else begin
         if (ptr_we_i)
            next_ptr_q <= ptr_wdata_i;
         else if (link_hit && !sw_hold_q)
            next_ptr_q <= mem_rdata_i[ADDR_W-1:0];

         if (ptr_we_i && (busy || launch))
            sw_hold_q <= 1'b1;
         else if (launch)
            sw_hold_q <= 1'b0;

         if (launch)
            fetch_base_q <= next_ptr_q;

         if (vsync_i)
            field_q <= ~field_q;

         if (complete && staged.ctrl[DEFER_BIT])
            pending_q <= 1'b1;
         else if (vsync_i)
            pending_q <= 1'b0;

         if (bad_launch)
            err_q <= 1'b1;

         if (underflow_i)
            unf_q <= 1'b1;
         else if (commit)
            unf_q <= 1'b0;
      end
   end

   pnl_fetch_seq #(.ADDR_W(ADDR_W)) u_seq (
      .clk          (clk),
      .rst_n        (rst_n),
      .start_i      (launch),
      .base_i       (next_ptr_q),
      .mem_rvalid_i (mem_rvalid_i),
      .mem_req_o    (mem_req_o),
      .mem_addr_o   (mem_addr_o),
      .busy_o       (seq_busy),
      .word_valid_o (word_valid),
      .word_idx_o   (word_idx)
   );

   pnl_node_stage u_stage (
      .clk          (clk),
      .rst_n        (rst_n),
      .word_valid_i (word_valid),
      .word_idx_i   (word_idx),
      .word_data_i  (mem_rdata_i),
      .node_o       (staged),
      .complete_o   (complete)
   );

   pnl_shadow #(
      .ADDR_W   (ADDR_W),
      .MAX_W    (MAX_W),
      .MAX_H    (MAX_H),
      .CLAMP_EN (CLAMP_EN)
   ) u_shadow (
      .clk      (clk),
      .rst_n    (rst_n),
      .commit_i (commit),
      .node_i   (staged),
      .addr_i   (fetch_base_q),
      .node_o   (shadow),
      .addr_o   (loaded_addr_o)
   );

   assign cfg_ctrl_o     = shadow.ctrl;
   assign cfg_alpha_o    = shadow.alpha;
   assign cfg_origin_o   = shadow.origin;
   assign cfg_stop_o     = shadow.stop;
   assign cfg_pix_addr_o = shadow.pix_addr;
   assign cfg_pitch_o    = shadow.pitch;
   assign cfg_size_o     = shadow.size;
   assign cfg_key_a_o    = shadow.key_a;
   assign cfg_key_b_o    = shadow.key_b;
   assign cfg_props_o    = shadow.props;
   assign cfg_clut_o     = shadow.clut;
   assign plane_hidden_o = |shadow.props[1:0];
   assign field_bot_o    = field_q;
   assign underflow_o    = unf_q;
   assign align_err_o    = err_q;
endmodule

// File: rtl/pnl_checker.sv
module pnl_checker #(
   parameter int unsigned ADDR_W     = 32,
   parameter int unsigned ALIGN_BITS = 4,
   parameter int unsigned MAX_W      = 3840,
   parameter int unsigned MAX_H      = 2160,
   parameter bit          CLAMP_EN   = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              vsync,
   input logic              mem_req,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [ADDR_W-1:0] next_ptr,
   input logic              busy,
   input logic              commit,
   input logic              field,
   input logic              align_err,
   input logic              underflow_in,
   input logic              underflow_out,
   input logic [31:0]       cfg_ctrl,
   input logic [31:0]       cfg_size,
   input logic [ADDR_W-1:0] loaded_addr
);
   a_r2_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |=> !mem_req);

   a_r2_word_aligned: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> (mem_addr[1:0] == 2'b00));

   a_r3_zero_no_fetch: assert property (@(posedge clk) disable iff (!rst_n)
      (vsync && !busy && (next_ptr == '0)) |=> !mem_req);

   a_r4_misaligned_no_fetch: assert property (@(posedge clk) disable iff (!rst_n)
      (vsync && !busy && (next_ptr != '0) && (|next_ptr[ALIGN_BITS-1:0]))
         |=> (!mem_req && align_err));

   a_r4_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      align_err |=> align_err);

   a_r5_shadow_stable: assert property (@(posedge clk) disable iff (!rst_n)
      !commit |=> ($stable(cfg_ctrl) && $stable(cfg_size) && $stable(loaded_addr)));

   a_r9_field_toggle: assert property (@(posedge clk) disable iff (!rst_n)
      vsync |=> (field != $past(field)));

   a_r9_field_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !vsync |=> $stable(field));

   a_r11_size_limit: assert property (@(posedge clk) disable iff (!rst_n)
      !CLAMP_EN || ((32'(cfg_size[15:0]) <= MAX_W) && (32'(cfg_size[31:16]) <= MAX_H)));

   a_r12_underflow_set: assert property (@(posedge clk) disable iff (!rst_n)
      underflow_in |=> underflow_out);
endmodule

bind plane_node_loader pnl_checker #(
   .ADDR_W     (ADDR_W),
   .ALIGN_BITS (ALIGN_BITS),
   .MAX_W      (MAX_W),
   .MAX_H      (MAX_H),
   .CLAMP_EN   (CLAMP_EN)
) u_pnl_checker (
   .clk           (clk),
   .rst_n         (rst_n),
   .vsync         (vsync_i),
   .mem_req       (mem_req_o),
   .mem_addr      (mem_addr_o),
   .next_ptr      (next_ptr_q),
   .busy          (busy),
   .commit        (commit),
   .field         (field_bot_o),
   .align_err     (align_err_o),
   .underflow_in  (underflow_i),
   .underflow_out (underflow_o),
   .cfg_ctrl      (cfg_ctrl_o),
   .cfg_size      (cfg_size_o),
   .loaded_addr   (loaded_addr_o)
);

// File: tb/test_plane_node_loader.sv
`timescale 1ns/1ps
module test_plane_node_loader;
   localparam int unsigned TB_MAX_W = 320;
   localparam int unsigned TB_MAX_H = 240;
   localparam int FETCH_WAIT = 80;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        vsync = 1'b0;
   logic        ptr_we = 1'b0;
   logic [31:0] ptr_wdata = '0;
   logic        mem_req;
   logic [31:0] mem_addr;
   logic        mem_rvalid;
   logic [31:0] mem_rdata;
   logic        underflow_in = 1'b0;
   logic [31:0] cfg_ctrl, cfg_alpha, cfg_origin, cfg_stop, cfg_pix_addr, cfg_pitch;
   logic [31:0] cfg_size, cfg_key_a, cfg_key_b, cfg_props, cfg_clut;
   logic [31:0] loaded_addr;
   logic        field_bot, hidden, underflow_out, align_err;

   always #10 clk = ~clk;

   plane_node_loader #(
      .ADDR_W(32), .ALIGN_BITS(4), .MAX_W(TB_MAX_W), .MAX_H(TB_MAX_H), .CLAMP_EN(1'b1)
   ) i_plane_node_loader (
      .clk(clk), .rst_n(rst_n), .vsync_i(vsync), .ptr_we_i(ptr_we), .ptr_wdata_i(ptr_wdata),
      .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata),
      .underflow_i(underflow_in),
      .cfg_ctrl_o(cfg_ctrl), .cfg_alpha_o(cfg_alpha), .cfg_origin_o(cfg_origin), .cfg_stop_o(cfg_stop),
      .cfg_pix_addr_o(cfg_pix_addr), .cfg_pitch_o(cfg_pitch), .cfg_size_o(cfg_size),
      .cfg_key_a_o(cfg_key_a), .cfg_key_b_o(cfg_key_b), .cfg_props_o(cfg_props), .cfg_clut_o(cfg_clut),
      .loaded_addr_o(loaded_addr), .field_bot_o(field_bot), .plane_hidden_o(hidden),
      .underflow_o(underflow_out), .align_err_o(align_err)
   );

   // memory model: answers two cycles after each request
   logic [31:0] mem_arr [256];
   logic        m_r1 = 1'b0, m_rv = 1'b0;
   logic [31:0] m_a1 = '0, m_rd = '0;
   always @(posedge clk) begin
      m_r1 <= mem_req;
      m_a1 <= mem_addr;
      m_rv <= m_r1;
      m_rd <= mem_arr[m_a1[9:2]];
   end
   assign mem_rvalid = m_rv;
   assign mem_rdata  = m_rd;

   // request log
   int          req_cnt = 0;
   logic [31:0] req_log [256];
   always @(posedge clk) begin
      if (rst_n && mem_req) begin
         req_log[req_cnt[7:0]] <= mem_addr;
         req_cnt <= req_cnt + 1;
      end
   end

   int n_tests = 0;
   int n_fail  = 0;
   logic exp_field = 1'b0;

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] fill_word(input logic [7:0] tag, input int k);
      return {tag, 8'(k), 16'hC0DE};
   endfunction

   task automatic put_node(input int base, input logic [7:0] tag, input logic [31:0] ctrl,
                           input logic [31:0] link, input logic [31:0] props, input logic [31:0] size);
      for (int k = 0; k < 16; k++) mem_arr[(base >> 2) + k] = fill_word(tag, k);
      mem_arr[(base >> 2) + 0]  = ctrl;
      mem_arr[(base >> 2) + 9]  = link;
      mem_arr[(base >> 2) + 13] = props;
      mem_arr[(base >> 2) + 7]  = size;
   endtask

   task automatic check_node(input string req, input logic [7:0] tag, input logic [31:0] ctrl,
                             input logic [31:0] props, input logic [31:0] size_exp);
      check({req, " ctrl"},   cfg_ctrl,     ctrl);
      check({req, " alpha"},  cfg_alpha,    fill_word(tag, 1));
      check({req, " origin"}, cfg_origin,   fill_word(tag, 3));
      check({req, " stop"},   cfg_stop,     fill_word(tag, 4));
      check({req, " pixadr"}, cfg_pix_addr, fill_word(tag, 5));
      check({req, " pitch"},  cfg_pitch,    fill_word(tag, 6));
      check({req, " size"},   cfg_size,     size_exp);
      check({req, " key_a"},  cfg_key_a,    fill_word(tag, 10));
      check({req, " key_b"},  cfg_key_b,    fill_word(tag, 11));
      check({req, " props"},  cfg_props,    props);
      check({req, " clut"},   cfg_clut,     fill_word(tag, 15));
   endtask

   task automatic pulse_vsync();
      @(negedge clk) vsync = 1'b1;
      @(negedge clk) vsync = 1'b0;
      exp_field = ~exp_field;
   endtask

   task automatic sw_write(input logic [31:0] v);
      @(negedge clk) begin ptr_we = 1'b1; ptr_wdata = v; end
      @(negedge clk) ptr_we = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check_reads(input string req, input int first, input logic [31:0] base);
      check({req, " read count"}, 32'(req_cnt - first), 32'd16);
      for (int k = 0; k < 16; k++)
         check({req, " read addr"}, req_log[8'(first + k)], base + 32'(4 * k));
   endtask

   task automatic t_reset();
      check("R1 ctrl", cfg_ctrl, 0);
      check("R1 size", cfg_size, 0);
      check("R1 loaded", loaded_addr, 0);
      check("R1 field", 32'(field_bot), 0);
      check("R1 err", 32'(align_err), 0);
      check("R1 underflow", 32'(underflow_out), 0);
      check("R1 reads", 32'(req_cnt), 0);
   endtask

   task automatic t_zero_ptr();
      int c0 = req_cnt;
      pulse_vsync();
      idle(10);
      check("R3 no read on zero pointer", 32'(req_cnt - c0), 0);
      check("R9 field toggled", 32'(field_bot), 32'(exp_field));
   endtask

   task automatic t_basic();
      int c0;
      put_node(32'h100, 8'hA1, 32'h0000_0005, 32'h200, 32'h0, {16'd240, 16'd320});
      sw_write(32'h100);
      c0 = req_cnt;
      pulse_vsync();
      idle(30);
      check("R5 no partial ctrl", cfg_ctrl, 0);
      check("R5 no partial addr", loaded_addr, 0);
      idle(FETCH_WAIT);
      check_reads("R2", c0, 32'h100);
      check_node("R5 node A", 8'hA1, 32'h0000_0005, 32'h0, {16'd240, 16'd320});
      check("R5 loaded addr A", loaded_addr, 32'h100);
      check("R10 visible A", 32'(hidden), 0);
      check("R9 field", 32'(field_bot), 32'(exp_field));
   endtask

   task automatic t_link();
      int c0 = req_cnt;
      put_node(32'h200, 8'hB2, 32'h0000_0001, 32'h100, 32'h1, {16'd3000, 16'd5000});
      pulse_vsync();
      idle(FETCH_WAIT);
      check_reads("R6 link", c0, 32'h200);
      check("R6 loaded via link", loaded_addr, 32'h200);
      check("R10 hidden bit0", 32'(hidden), 1);
      check("R11 clamped size", cfg_size, {16'(TB_MAX_H), 16'(TB_MAX_W)});
   endtask

   task automatic t_deferred();
      int c0;
      put_node(32'h300, 8'hC3, 32'h8000_0002, 32'h0, 32'h2, {16'd10, 16'd20});
      sw_write(32'h300);
      c0 = req_cnt;
      pulse_vsync();
      idle(FETCH_WAIT);
      check("R8 fetched", 32'(req_cnt - c0), 16);
      check("R8 held back addr", loaded_addr, 32'h200);
      check("R8 held back ctrl", cfg_ctrl, 32'h0000_0001);
      c0 = req_cnt;
      pulse_vsync();
      check("R8 commit at vsync addr", loaded_addr, 32'h300);
      check_node("R8 node C", 8'hC3, 32'h8000_0002, 32'h2, {16'd10, 16'd20});
      check("R10 hidden bit1", 32'(hidden), 1);
      idle(10);
      check("R6 zero link no read", 32'(req_cnt - c0), 0);
   endtask

   task automatic t_misaligned();
      int c0;
      sw_write(32'h104);
      c0 = req_cnt;
      pulse_vsync();
      idle(10);
      check("R4 no read", 32'(req_cnt - c0), 0);
      check("R4 error set", 32'(align_err), 1);
      check("R4 addr kept", loaded_addr, 32'h300);
      check("R4 ctrl kept", cfg_ctrl, 32'h8000_0002);
   endtask

   task automatic t_sw_during_fetch();
      int c0;
      put_node(32'h380, 8'hD4, 32'h0000_0003, 32'h100, 32'h4, {16'd5, 16'd6});
      sw_write(32'h380);
      c0 = req_cnt;
      pulse_vsync();
      idle(20);
      sw_write(32'h200);
      pulse_vsync();
      idle(FETCH_WAIT);
      check_reads("R7 fetch not aborted", c0, 32'h380);
      check("R7 loaded D", loaded_addr, 32'h380);
      check("R10 bit2 only visible", 32'(hidden), 0);
      check("R9 field with busy vsync", 32'(field_bot), 32'(exp_field));
      pulse_vsync();
      idle(FETCH_WAIT);
      check("R7 written pointer wins over link", loaded_addr, 32'h200);
   endtask

   task automatic t_underflow();
      @(negedge clk) underflow_in = 1'b1;
      @(negedge clk) underflow_in = 1'b0;
      idle(2);
      check("R12 underflow set", 32'(underflow_out), 1);
      pulse_vsync();
      idle(FETCH_WAIT);
      check("R12 loaded A again", loaded_addr, 32'h100);
      check("R12 underflow cleared", 32'(underflow_out), 0);
      check("R4 error still sticky", 32'(align_err), 1);
   endtask

   initial begin
      for (int i = 0; i < 256; i++) mem_arr[i] = '0;
      fork
         begin
            idle(4);
            @(negedge clk) rst_n = 1'b1;
            idle(2);
            t_reset();
            t_zero_ptr();
            t_basic();
            t_link();
            t_deferred();
            t_misaligned();
            t_sw_during_fetch();
            t_underflow();
         end
         begin
            repeat (100000) @(posedge clk);
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule